// File: doc/BRIEF.md
# Routing Multiplexer with Binary-Coded Level Selects

This block is a parameterized routing multiplexer whose configuration is held as small binary codes instead of one-hot select bits. The data inputs pass through a cascade of levels. Every level is built from groups of X inputs, and all groups of one level share one code. A local decoder turns the code for a level into one-hot pass enables. Code k (1 to X) passes input k-1 of each group. Code zero, and any code above X, pass nothing at that level, so the output falls to a defined 0.

The basis X is the smallest integer of at least 2 whose power over the level count covers the input count. Input positions past the real inputs are padding that reads as 0. Each level's field is ceil(log2(X+1)) bits wide, so the configuration word costs levels × that width. Level 0, the level facing the inputs, occupies the least significant field. A single-level build decodes one code over all inputs. A two-input build is the exception: it takes a plain one-bit select with no off state. The block is purely combinational. It drives one output from a data vector and a packed configuration word.

Top module: `enc_route_mux`

## Requirements
- R1: The configuration word is split into equal fields of W = ceil(log2(X+1)) bits, one per level. Level l occupies bits [l*W +: W], so level 0 sits in the lowest field.
- R2: For every code value, a level's decoder enables at most one of its X legs.
- R3: When any level's code is 0, `dout` is 0 whatever the data.
- R4: When every level code k_l lies in 1..X, `dout` equals `din[idx]`, where idx = sum over l of (k_l-1)·X^l, provided idx < NUM_IN.
- R5: When any level's code is greater than X, `dout` is 0.
- R6: When all codes are valid but idx ≥ NUM_IN (a padding position), `dout` is 0.
- R7: With NUM_LEVELS = 1, a single code of ceil(log2(NUM_IN+1)) bits selects among all inputs directly (X = NUM_IN).
- R8: With NUM_IN = 2, the configuration is one bit: 0 routes `din[0]` and 1 routes `din[1]`, with no disconnect state.
- R9: The output follows `din` and `cfg` combinationally, within the same cycle and with no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | NUM_IN | Data inputs to be routed |
| cfg  | input  | CFG_W (levels × W, or 1 for two inputs) | Packed per-level binary codes, level 0 lowest |
| dout | output | 1 | Routed data output |

## Verification
Assertions inside the decoder check three things on every evaluation: that the enables are one-hot or empty, that code zero and codes above X produce no enable, and that a valid code turns on its own leg. At the top, assertions compare the output with an arithmetic index model: zero on any dead or out-of-range field, zero on padding, and the addressed input otherwise. Only the bench's scenarios can show that the field layout and the basis chosen for each parameter set route the intended physical input. They also cover the two-input and single-level variants, which it reaches by sweeping every code with walking-one and walking-zero data.

// File: rtl/emx_pkg.sv
package emx_pkg;

    function automatic int emx_levels(input int n_in, input int n_lev);
        if (n_in <= 2) return 1;
        if (n_lev < 1) return 1;
        return n_lev;
    endfunction

    function automatic int emx_pow(input int base, input int ex);
        int acc;
        acc = 1;
        for (int i = 0; i < ex; i++) acc = acc * base;
        return acc;
    endfunction

    // Smallest basis (>= 2) whose power over the level count covers n_in.
    function automatic int emx_basis(input int n_in, input int lev);
        if (n_in <= 2) return 2;
        for (int x = 2; x <= n_in; x++) begin
            if (emx_pow(x, lev) >= n_in) return x;
        end
        return n_in;
    endfunction

    function automatic int emx_code_w(input int n_in, input int x);
        if (n_in <= 2) return 1;
        return $clog2(x + 1);
    endfunction

endpackage

// File: rtl/emx_code_decoder.sv
module emx_code_decoder #(
    parameter int X = 3,
    parameter int W = 2
) (
    input  logic [W-1:0] code,
    output logic [X-1:0] hot
);

    // Code k in 1..X enables leg k-1; 0 and codes above X enable nothing.
    for (genvar i = 0; i < X; i++) begin : g_bit
        assign hot[i] = (code == W'(i + 1));
    end

    always_comb begin
        logic [X-1:0] probe;
        probe = hot >> (code - W'(1));
        p_onehot_r2: assert ($onehot0(hot))
            else $error("decoder enables more than one leg");
        if (code == '0) begin
            p_zero_off_r3: assert (hot == '0)
                else $error("zero code left a leg enabled");
        end
        if (code != '0 && int'(code) <= X) begin
            p_reach_r4: assert (probe[0])
                else $error("valid code did not enable its leg");
        end
        if (int'(code) > X) begin
            p_over_r5: assert (hot == '0)
                else $error("out-of-range code enabled a leg");
        end
    end

endmodule

// File: rtl/emx_level_stage.sv
module emx_level_stage #(
    parameter int X = 3
) (
    input  logic [X-1:0] hot,
    input  logic [X-1:0] leg,
    output logic         y
);

    // AND-OR pass network: with no enable the node settles at 0.
    assign y = |(hot & leg);

endmodule

// File: rtl/enc_route_mux.sv
module enc_route_mux #(
    parameter int NUM_IN     = 7,
    parameter int NUM_LEVELS = 2,
    localparam int LV    = emx_pkg::emx_levels(NUM_IN, NUM_LEVELS),
    localparam int X     = emx_pkg::emx_basis(NUM_IN, LV),
    localparam int W     = emx_pkg::emx_code_w(NUM_IN, X),
    localparam int CFG_W = (NUM_IN <= 2) ? 1 : LV * W
) (
    input  logic [NUM_IN-1:0] din,
    input  logic [CFG_W-1:0]  cfg,
    output logic              dout
);

    localparam int SPAN = emx_pkg::emx_pow(X, LV);

    if (NUM_IN <= 2) begin : g_plain
        // Two inputs: plain select bit, no off state.
        assign dout = cfg[0] ? din[NUM_IN-1] : din[0];
    end else begin : g_coded
        logic [SPAN-1:0] padded;
        assign padded = SPAN'(din);

        for (genvar l = 0; l < LV; l++) begin : g_lvl
            localparam int GROUPS = emx_pkg::emx_pow(X, LV - 1 - l);
            logic [X-1:0]        hot;
            logic [X*GROUPS-1:0] src;
            logic [GROUPS-1:0]   nxt;

            if (l == 0) begin : g_first
                assign src = padded;
            end else begin : g_inner
                assign src = g_lvl[l-1].nxt;
            end

            emx_code_decoder #(.X(X), .W(W)) dec_i (
                .code (cfg[l*W +: W]),
                .hot  (hot)
            );

            for (genvar g = 0; g < GROUPS; g++) begin : g_grp
                emx_level_stage #(.X(X)) stg_i (
                    .hot (hot),
                    .leg (src[g*X +: X]),
                    .y   (nxt[g])
                );
            end
        end

        assign dout = g_lvl[LV-1].nxt[0];

        // Arithmetic index model of the path, compared against the network.
        always_comb begin
            logic [W-1:0]      code_v;
            logic [NUM_IN-1:0] shifted;
            int  idx;
            int  mult;
            bit  dead;
            bit  over;
            idx  = 0;
            mult = 1;
            dead = 1'b0;
            over = 1'b0;
            for (int l = 0; l < LV; l++) begin
                code_v = cfg[l*W +: W];
                if (code_v == '0) dead = 1'b1;
                else if (int'(code_v) > X) over = 1'b1;
                else idx = idx + (int'(code_v) - 1) * mult;
                mult = mult * X;
            end
            shifted = din >> idx;
            if (dead) begin
                p_dead_level_r3: assert (dout == 1'b0)
                    else $error("zero code did not silence output");
            end else if (over) begin
                p_over_level_r5: assert (dout == 1'b0)
                    else $error("out-of-range code did not silence output");
            end else if (idx >= NUM_IN) begin
                p_padding_r6: assert (dout == 1'b0)
                    else $error("padding position drove a one");
            end else begin
                p_route_r4: assert (dout == shifted[0])
                    else $error("output differs from addressed input");
            end
        end
    end

endmodule

// File: tb/enc_route_mux_tb_top.sv
module enc_route_mux_tb_top;

    function automatic int tb_basis(input int nin, input int lv);
        int x;
        int p;
        if (nin <= 2) return 2;
        x = 2;
        forever begin
            p = 1;
            for (int i = 0; i < lv; i++) p = p * x;
            if (p >= nin) return x;
            x++;
        end
    endfunction

    function automatic int tb_width(input int nin, input int x);
        int w;
        if (nin <= 2) return 1;
        w = 0;
        while ((1 << w) < x + 1) w++;
        return w;
    endfunction

    localparam int A_IN = 7,  A_LV = 2, A_W = A_LV * tb_width(A_IN, tb_basis(A_IN, A_LV));
    localparam int B_IN = 20, B_LV = 3, B_W = B_LV * tb_width(B_IN, tb_basis(B_IN, B_LV));
    localparam int C_IN = 5,  C_LV = 1, C_W = C_LV * tb_width(C_IN, tb_basis(C_IN, C_LV));
    localparam int D_IN = 2,  D_LV = 1, D_W = 1;
    localparam int E_IN = 16, E_LV = 2, E_W = E_LV * tb_width(E_IN, tb_basis(E_IN, E_LV));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] d   = '0;
    logic [7:0]  c   = '0;
    logic        out_a, out_b, out_c, out_d, out_e;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    enc_route_mux #(.NUM_IN(A_IN), .NUM_LEVELS(A_LV)) dut_i (
        .din (d[A_IN-1:0]), .cfg (c[A_W-1:0]), .dout (out_a));
    enc_route_mux #(.NUM_IN(B_IN), .NUM_LEVELS(B_LV)) dut_b (
        .din (d[B_IN-1:0]), .cfg (c[B_W-1:0]), .dout (out_b));
    enc_route_mux #(.NUM_IN(C_IN), .NUM_LEVELS(C_LV)) dut_c (
        .din (d[C_IN-1:0]), .cfg (c[C_W-1:0]), .dout (out_c));
    enc_route_mux #(.NUM_IN(D_IN), .NUM_LEVELS(2)) dut_d (
        .din (d[D_IN-1:0]), .cfg (c[D_W-1:0]), .dout (out_d));
    enc_route_mux #(.NUM_IN(E_IN), .NUM_LEVELS(E_LV)) dut_e (
        .din (d[E_IN-1:0]), .cfg (c[E_W-1:0]), .dout (out_e));

    function automatic bit pick(input int sel);
        case (sel)
            0: return out_a;
            1: return out_b;
            2: return out_c;
            3: return out_d;
            default: return out_e;
        endcase
    endfunction

    // Reference built from the requirements: decode fields, form the index.
    function automatic bit expect_bit(input logic [31:0] dv, input int cv,
                                      input int nin, input int nlev,
                                      output string tag);
        int x, w, idx, mult, k;
        bit dead0, over;
        if (nin <= 2) begin
            tag = "R8";
            return cv[0] ? dv[1] : dv[0];
        end
        x = tb_basis(nin, nlev);
        w = tb_width(nin, x);
        idx = 0; mult = 1; dead0 = 0; over = 0;
        for (int l = 0; l < nlev; l++) begin
            k = (cv >> (l * w)) & ((1 << w) - 1);
            if (k == 0) dead0 = 1;
            else if (k > x) over = 1;
            else idx = idx + (k - 1) * mult;
            mult = mult * x;
        end
        if (dead0)          begin tag = (nlev == 1) ? "R7 R3" : "R3"; return 1'b0; end
        if (over)           begin tag = (nlev == 1) ? "R7 R5" : "R5"; return 1'b0; end
        if (idx >= nin)     begin tag = "R6"; return 1'b0; end
        tag = (nlev == 1) ? "R7 R4 R2 R9" : "R4 R1 R2 R9";
        return dv[idx];
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cfg=%0h din=%0h actual=%b expected=%b", tag, c, d, act, exp);
        end
    endtask

    task automatic apply_and_check(input int sel, input int nin, input int nlev,
                                   input int cv, input logic [31:0] dv);
        string tag;
        bit    exp;
        @(posedge clk);
        c = 8'(cv);
        d = dv;
        @(negedge clk);
        exp = expect_bit(dv, cv, nin, nlev, tag);
        check(tag, pick(sel), exp);
    endtask

    // Every code value against all-ones, all-zeros, walking one and walking zero.
    task automatic sweep(input int sel, input int nin, input int nlev, input int cw);
        logic [31:0] mask;
        mask = (32'h1 << nin) - 32'h1;
        for (int cv = 0; cv < (1 << cw); cv++) begin
            apply_and_check(sel, nin, nlev, cv, mask);
            apply_and_check(sel, nin, nlev, cv, 32'h0);
            for (int i = 0; i < nin; i++) begin
                apply_and_check(sel, nin, nlev, cv, 32'h1 << i);
                apply_and_check(sel, nin, nlev, cv, mask & ~(32'h1 << i));
            end
        end
    endtask

    task automatic t_reset_state;
        string tag;
        @(negedge clk);
        check("R3 reset", out_a, 1'b0);
        check("R3 reset", out_e, 1'b0);
        tag = "R3";
        d = 32'hFFFF_FFFF;
        @(negedge clk);
        check({tag, " all-ones data, zero cfg"}, out_b, 1'b0);
    endtask

    task automatic t_two_level_padded;  sweep(0, A_IN, A_LV, A_W); endtask
    task automatic t_three_level;       sweep(1, B_IN, B_LV, B_W); endtask
    task automatic t_single_level;      sweep(2, C_IN, C_LV, C_W); endtask
    task automatic t_two_input_plain;   sweep(3, D_IN, D_LV, D_W); endtask
    task automatic t_over_range_codes;  sweep(4, E_IN, E_LV, E_W); endtask

    task automatic t_same_cycle_r9;
        // cfg level0=2, level1=1 selects input 1 on the 7-input build.
        @(posedge clk);
        c = 8'h6;
        d = 32'h2;
        #1;
        check("R9 same-cycle rise", out_a, 1'b1);
        d = 32'h0;
        #1;
        check("R9 same-cycle fall", out_a, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_two_level_padded();
        t_three_level();
        t_single_level();
        t_two_input_plain();
        t_over_range_codes();
        t_same_cycle_r9();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule